// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a small write-back, write-allocate cache built around a direct-mapped line array, with a four-entry fully associative victim buffer beside it. Each cache line holds one data word. Any line pushed out of the direct-mapped array is kept in the victim buffer. Two addresses that share an index and are used in turn are then served by exchanging the two lines between the array and the buffer. They do not go back to the next level each time.

The processor side uses a valid/ready request port. A request carries a word address, a write flag and write data. A one-cycle response pulse returns the read data, or the written word for a store. The block handles one request at a time, and ready stays low from acceptance until the response.

The lookup runs in order. The direct-mapped array is checked first. The victim buffer is probed only after the array misses. The next-level memory is used only when both miss. The next-level port is a held request (valid, write flag, address, data) that ends when the memory returns a single response pulse. A write carries its data on the request, and a read gets its data on the response. When both levels miss, a dirty victim-buffer entry at the replacement slot is written out before the fill read is issued.

Top module: `dmvc_cache`

## Requirements
- R1: After synchronous reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0. Every line and buffer entry is invalid, so the first access to any address goes to the next level.
- R2: A hit in the direct-mapped array raises rsp_valid for exactly one cycle, on the first rising edge after acceptance. A read returns the most recently written value of that address.
- R3: The victim buffer is probed only after an array miss. A buffer hit raises rsp_valid on the second rising edge after acceptance and causes no next-level traffic.
- R4: On a buffer hit, the requested line moves into the array, and the line it displaces takes the freed buffer entry in the same cycle. The displaced line therefore hits in the buffer on its next use.
- R5: A miss in both levels issues exactly one next-level read, of the requested address. The request is held stable until the memory response, and the response comes more than two edges after acceptance.
- R6: On a fill, the line leaving the array is placed in the buffer at a first-in-first-out slot among 4 entries. The oldest insertion is the one that is replaced.
- R7: A store that misses fetches the line, merges the word and marks it dirty. Dirty state stays with a line as it moves into and out of the buffer.
- R8: A dirty entry dropped from the buffer is written to the next level (mem_req_write = 1) before the fill read. A clean entry is dropped with no write.
- R9: req_ready is 0 from the cycle after acceptance until the response cycle. rsp_valid is only raised while req_ready is 1.
- R10: When two addresses with the same index are used alternately, no next-level read occurs after the first two fills.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 12 | Word address; low 3 bits are the index |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Load data, or the stored word |
| mem_req_valid | output | 1 | Next-level request, held until response |
| mem_req_write | output | 1 | 1 = write-back, 0 = fill read |
| mem_req_addr | output | 12 | Next-level word address |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Next-level completion pulse |
| mem_rsp_rdata | input | 32 | Fill data |

## Verification
An array hit answers on the first edge after the accepting edge, and a victim-buffer hit answers on the second. A miss answers only after the bench memory's fixed three-cycle turnaround, plus one more round trip when a write-back comes first. The bench drives inputs and samples outputs on falling edges. It counts rising edges from acceptance until rsp_valid is seen, so each case is checked against its exact edge count. It also compares how many reads and writes the memory model saw, before and after each access, with the number the requirements predict.

// File: rtl/dmvc_pkg.sv
package dmvc_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = 3;
    localparam int VB_N     = 4;
    localparam int TAG_W    = ADDR_W - IDX_W;
    localparam int LINES    = 1 << IDX_W;
    localparam int SLOT_W   = $clog2(VB_N);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic  valid;
        logic  dirty;
        tag_t  tag;
        data_t data;
    } dm_line_t;

    typedef struct packed {
        logic  valid;
        logic  dirty;
        addr_t addr;
        data_t data;
    } vb_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAG,
        ST_VB,
        ST_WB,
        ST_FILL
    } ctl_state_t;

    function automatic data_t merge_word(input logic wr, input data_t wd, input data_t old);
        return wr ? wd : old;
    endfunction

endpackage

// File: rtl/dmvc_dm_array.sv
module dmvc_dm_array
    import dmvc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  idx_t     rd_idx,
    input  tag_t     cmp_tag,
    output dm_line_t rd_line,
    output logic     hit,
    input  logic     wr_en,
    input  idx_t     wr_idx,
    input  dm_line_t wr_line
);

    dm_line_t lines [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                lines[i] <= '0;
            end
        end else if (wr_en) begin
            lines[wr_idx] <= wr_line;
        end
    end

    assign rd_line = lines[rd_idx];
    assign hit     = rd_line.valid && (rd_line.tag == cmp_tag);

endmodule

// File: rtl/dmvc_vbuf.sv
module dmvc_vbuf
    import dmvc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  addr_t     look_addr,
    output logic      hit,
    output slot_t     hit_slot,
    output vb_entry_t hit_entry,
    output slot_t     fifo_slot,
    output vb_entry_t fifo_entry,
    input  logic      wr_en,
    input  slot_t     wr_slot,
    input  vb_entry_t wr_entry,
    input  logic      adv
);

    vb_entry_t         ents [VB_N];
    logic [VB_N-1:0]   match;
    slot_t             ptr;

    for (genvar g = 0; g < VB_N; g++) begin : g_cmp
        assign match[g] = ents[g].valid && (ents[g].addr == look_addr);
    end

    always_comb begin
        hit_slot = '0;
        for (int i = 0; i < VB_N; i++) begin
            if (match[i]) hit_slot = slot_t'(i);
        end
    end

    assign hit        = |match;
    assign hit_entry  = ents[hit_slot];
    assign fifo_slot  = ptr;
    assign fifo_entry = ents[ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            for (int i = 0; i < VB_N; i++) begin
                ents[i] <= '0;
            end
        end else begin
            if (wr_en) ents[wr_slot] <= wr_entry;
            if (adv) ptr <= (ptr == slot_t'(VB_N - 1)) ? '0 : slot_t'(ptr + 1'b1);
        end
    end

endmodule

// File: rtl/dmvc_cache.sv
module dmvc_cache
    import dmvc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [11:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        mem_req_valid,
    output logic        mem_req_write,
    output logic [11:0] mem_req_addr,
    output logic [31:0] mem_req_wdata,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_rdata
);

    ctl_state_t state, state_n;
    logic       q_write;
    addr_t      q_addr;
    data_t      q_wdata;
    idx_t       q_idx;
    tag_t       q_tag;

    dm_line_t   dm_rd, dm_wline;
    logic       dm_hit, dm_we;

    logic       vb_hit, vb_we, vb_adv;
    slot_t      vb_hit_slot, vb_fifo_slot, vb_wslot;
    vb_entry_t  vb_hit_entry, vb_fifo_entry, vb_wentry, ev_entry;

    logic       rsp_set;
    data_t      rsp_data_n;

    assign q_idx = q_addr[IDX_W-1:0];
    assign q_tag = q_addr[ADDR_W-1:IDX_W];

    dmvc_dm_array u_array (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (q_idx),
        .cmp_tag (q_tag),
        .rd_line (dm_rd),
        .hit     (dm_hit),
        .wr_en   (dm_we),
        .wr_idx  (q_idx),
        .wr_line (dm_wline)
    );

    dmvc_vbuf u_vbuf (
        .clk        (clk),
        .rst        (rst),
        .look_addr  (q_addr),
        .hit        (vb_hit),
        .hit_slot   (vb_hit_slot),
        .hit_entry  (vb_hit_entry),
        .fifo_slot  (vb_fifo_slot),
        .fifo_entry (vb_fifo_entry),
        .wr_en      (vb_we),
        .wr_slot    (vb_wslot),
        .wr_entry   (vb_wentry),
        .adv        (vb_adv)
    );

    // line leaving the array, in buffer form
    assign ev_entry = '{valid: dm_rd.valid, dirty: dm_rd.dirty,
                        addr: {dm_rd.tag, q_idx}, data: dm_rd.data};

    assign req_ready = (state == ST_IDLE);

    always_comb begin
        state_n       = state;
        dm_we         = 1'b0;
        dm_wline      = '0;
        vb_we         = 1'b0;
        vb_wslot      = vb_hit_slot;
        vb_wentry     = ev_entry;
        vb_adv        = 1'b0;
        rsp_set       = 1'b0;
        rsp_data_n    = '0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = q_addr;
        mem_req_wdata = '0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) state_n = ST_TAG;
            end
            ST_TAG: begin
                if (dm_hit) begin
                    rsp_set    = 1'b1;
                    rsp_data_n = merge_word(q_write, q_wdata, dm_rd.data);
                    if (q_write) begin
                        dm_we    = 1'b1;
                        dm_wline = '{valid: 1'b1, dirty: 1'b1, tag: q_tag, data: q_wdata};
                    end
                    state_n = ST_IDLE;
                end else begin
                    state_n = ST_VB;
                end
            end
            ST_VB: begin
                if (vb_hit) begin
                    // swap: buffer line up, array line down into the freed slot
                    rsp_set    = 1'b1;
                    rsp_data_n = merge_word(q_write, q_wdata, vb_hit_entry.data);
                    dm_we      = 1'b1;
                    dm_wline   = '{valid: 1'b1, dirty: vb_hit_entry.dirty | q_write,
                                   tag: q_tag, data: rsp_data_n};
                    vb_we      = 1'b1;
                    vb_wslot   = vb_hit_slot;
                    state_n    = ST_IDLE;
                end else if (dm_rd.valid && vb_fifo_entry.valid && vb_fifo_entry.dirty) begin
                    state_n = ST_WB;
                end else begin
                    state_n = ST_FILL;
                end
            end
            ST_WB: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = vb_fifo_entry.addr;
                mem_req_wdata = vb_fifo_entry.data;
                if (mem_rsp_valid) state_n = ST_FILL;
            end
            ST_FILL: begin
                mem_req_valid = 1'b1;
                if (mem_rsp_valid) begin
                    rsp_set    = 1'b1;
                    rsp_data_n = merge_word(q_write, q_wdata, mem_rsp_rdata);
                    dm_we      = 1'b1;
                    dm_wline   = '{valid: 1'b1, dirty: q_write, tag: q_tag, data: rsp_data_n};
                    if (dm_rd.valid) begin
                        vb_we    = 1'b1;
                        vb_wslot = vb_fifo_slot;
                        vb_adv   = 1'b1;
                    end
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            q_write   <= 1'b0;
            q_addr    <= '0;
            q_wdata   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            state     <= state_n;
            rsp_valid <= rsp_set;
            if (rsp_set) rsp_rdata <= rsp_data_n;
            if (state == ST_IDLE && req_valid) begin
                q_write <= req_write;
                q_addr  <= req_addr;
                q_wdata <= req_wdata;
            end
        end
    end

endmodule

// File: rtl/dmvc_cache_chk.sv
module dmvc_cache_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        mem_req_valid,
    input logic        mem_req_write,
    input logic [11:0] mem_req_addr,
    input logic        mem_rsp_valid
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_valid && !mem_req_valid));

    assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_no_mem_when_ready_R3: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req_valid);

    assert_mem_req_held_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_rsp_valid) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_only_ready_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready);

endmodule

bind dmvc_cache dmvc_cache_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/dmvc_cache_test.sv
module dmvc_cache_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;
    localparam int NV         = 20;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [1:0]  cls;   // 0 array hit, 1 buffer hit, 2 miss
        logic        wb;    // write-backs expected
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h010, 32'h0,        2'd2, 1'b0},
        '{1'b0, 12'h010, 32'h0,        2'd0, 1'b0},
        '{1'b0, 12'h020, 32'h0,        2'd2, 1'b0},
        '{1'b0, 12'h010, 32'h0,        2'd1, 1'b0},
        '{1'b0, 12'h020, 32'h0,        2'd1, 1'b0},
        '{1'b1, 12'h010, 32'h00001111, 2'd1, 1'b0},
        '{1'b0, 12'h010, 32'h0,        2'd0, 1'b0},
        '{1'b0, 12'h030, 32'h0,        2'd2, 1'b0},
        '{1'b0, 12'h040, 32'h0,        2'd2, 1'b0},
        '{1'b0, 12'h050, 32'h0,        2'd2, 1'b0},
        '{1'b0, 12'h060, 32'h0,        2'd2, 1'b0},
        '{1'b0, 12'h020, 32'h0,        2'd2, 1'b1},
        '{1'b0, 12'h010, 32'h0,        2'd2, 1'b0},
        '{1'b0, 12'h030, 32'h0,        2'd2, 1'b0},
        '{1'b0, 12'h010, 32'h0,        2'd1, 1'b0},
        '{1'b0, 12'h011, 32'h0,        2'd2, 1'b0},
        '{1'b1, 12'h012, 32'h00002222, 2'd2, 1'b0},
        '{1'b0, 12'h012, 32'h0,        2'd0, 1'b0},
        '{1'b0, 12'h020, 32'h0,        2'd1, 1'b0},
        '{1'b0, 12'h060, 32'h0,        2'd1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_req_valid;
    logic        mem_req_write;
    logic [11:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;

    int checks = 0;
    int errors = 0;
    int n_rd = 0;
    int n_wr = 0;
    int cyc = 0;
    int mcnt = 0;

    logic [31:0] mem     [4096];
    logic [31:0] ref_mem [4096];

    dmvc_cache uut (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // next-level memory: answers on the third edge of a held request
    always @(posedge clk) begin
        if (rst) begin
            mem_rsp_valid <= 1'b0;
            mcnt          <= 0;
        end else if (mem_rsp_valid) begin
            mem_rsp_valid <= 1'b0;
            mcnt          <= 0;
        end else if (mem_req_valid) begin
            if (mcnt == 2) begin
                mem_rsp_valid <= 1'b1;
                if (mem_req_write) begin
                    mem[mem_req_addr] <= mem_req_wdata;
                    n_wr <= n_wr + 1;
                end else begin
                    mem_rsp_rdata <= mem[mem_req_addr];
                    n_rd <= n_rd + 1;
                end
            end else begin
                mcnt <= mcnt + 1;
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL R9 watchdog: cycles %0d expected below %0d", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic do_req(input logic wr, input logic [11:0] a, input logic [31:0] d,
                          output int lat, output logic [31:0] rdata);
        @(negedge clk);
        check(req_ready == 1'b1, "R9", "ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R9", "ready low while busy", 32'(req_ready), 32'd0);
        lat = 0;
        while (!rsp_valid && lat < 40) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        rdata = rsp_rdata;
    endtask

    task automatic run_access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                              input logic [1:0] cls, input int wb);
        int          lat;
        int          rd0;
        int          wr0;
        logic [31:0] got;
        logic [31:0] exp;
        rd0 = n_rd;
        wr0 = n_wr;
        exp = wr ? d : ref_mem[a];
        do_req(wr, a, d, lat, got);
        if (wr) ref_mem[a] = d;
        check(got == exp, "R2 R7", "response data", got, exp);
        case (cls)
            2'd0: check(lat == 1, "R2", "array hit latency", 32'(lat), 32'd1);
            2'd1: check(lat == 2, "R3 R4", "buffer hit latency", 32'(lat), 32'd2);
            default: check(lat > 2 && lat < 40, "R5", "miss latency", 32'(lat), 32'd3);
        endcase
        check((n_rd - rd0) == ((cls == 2'd2) ? 1 : 0), "R5 R10", "next-level reads",
              32'(n_rd - rd0), (cls == 2'd2) ? 32'd1 : 32'd0);
        check((n_wr - wr0) == wb, "R6 R8", "next-level writes", 32'(n_wr - wr0), 32'(wb));
    endtask

    initial begin
        for (int a = 0; a < 4096; a++) begin
            mem[a]     = 32'hC0DE0000 ^ 32'(a);
            ref_mem[a] = 32'hC0DE0000 ^ 32'(a);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: ports idle after reset
        check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 32'(mem_req_valid), 32'd0);

        // vector table: R4 swaps, R6 FIFO drop order, R7 write-allocate, R8 dirty write-back
        for (int i = 0; i < NV; i++) begin
            run_access(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].cls, int'(VECS[i].wb));
        end

        // R1: reset mid-run empties the cache
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "idle after second reset",
              {30'd0, req_ready, rsp_valid}, 32'd2);
        run_access(1'b0, 12'h060, 32'h0, 2'd2, 0);   // R1: previously cached line misses

        // R10: ping-pong on one index
        begin
            int rd_start;
            rd_start = n_rd;
            for (int k = 0; k < 12; k++) begin
                logic [11:0] pa;
                pa = k[0] ? 12'h20D : 12'h105;
                run_access(1'b0, pa, 32'h0, (k < 2) ? 2'd2 : 2'd1, 0);
            end
            check((n_rd - rd_start) == 2, "R10", "ping-pong total reads",
                  32'(n_rd - rd_start), 32'd2);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule